// File: doc/BRIEF.md
# DMA Channel Request and Acknowledge Control

This block is the control slice of one DMA channel. It watches an active-low external transfer-request pin, wins the system bus through a request/grant pair, and runs each transfer unit as a read cycle followed by a write cycle. In single-address mode it runs one write-strobe cycle instead. An acknowledge strobe goes back to the requesting device. A seven-bit control word picks its polarity, picks the bus cycle it overlaps, and picks whether the request is taken as a low level or as a falling edge. The same word selects cycle-steal or burst bus use and a byte or word transfer unit.

Software loads a 16-bit unit count and writes the control word with its enable bit set. The channel then moves units until the count runs out. At that point it clears its own enable and raises a one-cycle completion pulse. Only channels 0 and 1 have the external request and acknowledge options. A higher channel number, set by parameter, ignores the request pin, transfers whenever it is enabled, and holds the acknowledge low.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Reset and a one-cycle `standby` pulse each clear every control bit to 0. Afterwards the bus is idle, no strobe is active, `ackOut` is 0 and `done` is 0. A channel cleared by standby does not start on a later request.
- R2: Control word layout: bit0 enable, bit1 unit size, bit2 burst, bit3 edge detect, bit4 active-low acknowledge, bit5 acknowledge in write, bit6 single-address. In dual-address mode every unit is one `rdStb` cycle followed at once by one `wrStb` cycle. Bit5 = 0 places the acknowledge on the read cycle, and bit5 = 1 places it on the write cycle.
- R3: With bit6 = 1, each unit is a single `wrStb` cycle with no `rdStb`. The acknowledge is active during that cycle whatever the value of bit5.
- R4: Bit4 = 0 makes the acknowledge active-high and bit4 = 1 makes it active-low. While it is inactive, `ackOut` equals bit4.
- R5: With bit3 = 0, a low level on `reqN` after a two-flop synchronizer requests a unit. The level is checked again before every unit. In burst mode a high level pauses the block and releases the bus, and a new low level resumes it.
- R6: With bit3 = 1, each falling edge of `reqN` latches one pending request. In cycle-steal mode each edge yields exactly one unit, and a level held low yields no more. In burst mode one edge runs the whole block. With no edge, no transfer starts.
- R7: In cycle-steal mode (bit2 = 0), `busReq` drops after each unit. In burst mode (bit2 = 1), it stays high from the first unit to the last.
- R8: During every strobe cycle, `sizeWord` equals bit1 (0 byte, 1 word).
- R9: The channel moves exactly as many units as the loaded count. After the last unit, `done` is high for one cycle and the enable is cleared, so no further transfers follow. A count of zero starts no transfer.
- R10: While `busGnt` is low, the channel holds `busReq` high and issues no strobe.
- R11: With parameter `CHAN_ID` of 2 or more, the channel ignores `reqN` and transfers whenever enabled. Its `ackOut` stays 0 whatever bits 3 to 5 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby entry, clears the control word |
| cfgWe | input | 1 | Control word write strobe |
| cfgData | input | 7 | Control word value |
| cntWe | input | 1 | Unit count write strobe |
| cntData | input | CNT_W | Unit count value |
| reqN | input | 1 | External transfer request, active low |
| ackOut | output | 1 | Transfer acknowledge, programmable polarity |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant |
| rdStb | output | 1 | Read cycle strobe |
| wrStb | output | 1 | Write cycle strobe |
| sizeWord | output | 1 | Unit size during strobes, 1 = word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps all 64 settings of the six option bits over a three-unit block. For each setting it counts read and write strobes, acknowledge cycles and bus sessions, and compares them with totals worked out from the options. An acknowledge on the wrong phase, an inverted polarity, or a burst that lets go of the bus would each change those totals. Directed cases cover the harder spots. A held-low level in edge mode must give only one unit, or the design is re-triggering on level. A level released mid-burst must free the bus, and a design that ignored the pause would run on to the end. A zero count must start nothing, a held-off grant must produce no strobes, and a standby pulse must wipe the enable and polarity. A higher-numbered channel must still move its units with the acknowledge pinned low.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  // Control word, MSB first: bit6 single-address ... bit0 enable
  typedef struct packed {
    logic singleAddr;
    logic ackInWrite;
    logic ackLow;
    logic edgeDetect;
    logic burst;
    logic sizeWord;
    logic enable;
  } chanCfgT;

  localparam int CFG_W = $bits(chanCfgT);

  // Strobes from control to datapath
  typedef struct packed {
    logic startUnit;
    logic unitDone;
    logic finish;
  } ctlStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_READ,
    ST_WRITE,
    ST_SINGLE
  } chanStateT;

endpackage

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit EXT_REQ     = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                standby,
  input  logic                cfgWe,
  input  logic [CFG_W-1:0]    cfgData,
  input  logic                cntWe,
  input  logic [CNT_W-1:0]    cntData,
  input  logic                reqN,
  input  ctlStrobeT           stb,
  output chanCfgT             cfg,
  output logic                cntZero,
  output logic                cntLast,
  output logic                reqOk
);

  // Channels without external request keep only size, burst, single and enable
  localparam logic [CFG_W-1:0] CFG_MASK = EXT_REQ ? 7'h7F : 7'h47;

  logic [CNT_W-1:0] unitCnt;

  always_ff @(posedge clk) begin
    if (!rstN || standby) begin
      cfg <= '0;
    end else if (cfgWe) begin
      cfg <= chanCfgT'(cfgData & CFG_MASK);
    end else if (stb.finish) begin
      cfg.enable <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitCnt <= '0;
    end else if (cntWe) begin
      unitCnt <= cntData;
    end else if (stb.unitDone && unitCnt != '0) begin
      unitCnt <= unitCnt - 1'b1;
    end
  end

  assign cntZero = (unitCnt == '0);
  assign cntLast = (unitCnt == {{(CNT_W-1){1'b0}}, 1'b1});

  generate
    if (EXT_REQ) begin : g_ext
      logic [SYNC_STAGES:0] syncChain;
      logic reqSync, reqPrev, fallSeen, pending;

      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-1:0], reqN};
      end

      assign reqSync  = syncChain[SYNC_STAGES-1];
      assign reqPrev  = syncChain[SYNC_STAGES];
      assign fallSeen = reqPrev & ~reqSync;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          pending <= 1'b0;
        end else if (stb.finish || !cfg.enable || !cfg.edgeDetect) begin
          pending <= 1'b0;
        end else if (fallSeen) begin
          pending <= 1'b1;
        end else if (stb.startUnit) begin
          pending <= 1'b0;
        end
      end

      assign reqOk = cfg.edgeDetect ? pending : ~reqSync;

      // R6: a pending request never survives a disabled channel
      AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
        !cfg.enable |=> !pending); // R6
    end else begin : g_auto
      assign reqOk = 1'b1;
    end
  endgenerate

  AST_FINISH_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> cntLast); // R9

  AST_STANDBY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> cfg == '0); // R1

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter bit EXT_ACK = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  chanCfgT   cfg,
  input  logic      cntZero,
  input  logic      cntLast,
  input  logic      reqOk,
  input  logic      busGnt,
  output ctlStrobeT stb,
  output logic      busReq,
  output logic      rdStb,
  output logic      wrStb,
  output logic      sizeWord,
  output logic      ackOut,
  output logic      done
);

  chanStateT state, stateNext;
  chanStateT unitFirst;
  logic ackActive;

  assign unitFirst = cfg.singleAddr ? ST_SINGLE : ST_READ;

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (cfg.enable && !cntZero && reqOk) stateNext = ST_ARB;
      end
      ST_ARB: begin
        if (!cfg.enable) begin
          stateNext = ST_IDLE;
        end else if (busGnt) begin
          stateNext     = unitFirst;
          stb.startUnit = 1'b1;
        end
      end
      ST_READ: stateNext = ST_WRITE;
      ST_WRITE, ST_SINGLE: begin
        stb.unitDone = 1'b1;
        if (cntLast) begin
          stb.finish = 1'b1;
          stateNext  = ST_IDLE;
        end else if (cfg.burst && cfg.enable && (cfg.edgeDetect || reqOk)) begin
          stb.startUnit = 1'b1;
          stateNext     = unitFirst;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= stb.finish;
    end
  end

  assign busReq   = (state != ST_IDLE);
  assign rdStb    = (state == ST_READ);
  assign wrStb    = (state == ST_WRITE) || (state == ST_SINGLE);
  assign sizeWord = (rdStb || wrStb) && cfg.sizeWord;

  assign ackActive = (state == ST_SINGLE) ||
                     (cfg.ackInWrite ? (state == ST_WRITE) : (state == ST_READ));

  generate
    if (EXT_ACK) begin : g_ack
      assign ackOut = ackActive ^ cfg.ackLow;
    end else begin : g_noack
      assign ackOut = 1'b0;
    end
  endgenerate

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb && wrStb)); // R2

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> wrStb); // R2

  AST_NO_GRANT_NO_STB: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARB && !busGnt) |=> !rdStb && !wrStb); // R10

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !cfg.burst) |=> !busReq); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> ackOut == (EXT_ACK && cfg.ackLow)); // R4

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int CHAN_ID     = 0,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic             cfgWe,
  input  logic [6:0]       cfgData,
  input  logic             cntWe,
  input  logic [CNT_W-1:0] cntData,
  input  logic             reqN,
  output logic             ackOut,
  output logic             busReq,
  input  logic             busGnt,
  output logic             rdStb,
  output logic             wrStb,
  output logic             sizeWord,
  output logic             done
);

  localparam bit EXT_PINS = (CHAN_ID < 2);

  chanCfgT   cfg;
  ctlStrobeT stb;
  logic      cntZero, cntLast, reqOk;

  dma_chan_dp #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .EXT_REQ(EXT_PINS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .standby(standby),
    .cfgWe(cfgWe), .cfgData(cfgData), .cntWe(cntWe), .cntData(cntData),
    .reqN(reqN), .stb(stb), .cfg(cfg),
    .cntZero(cntZero), .cntLast(cntLast), .reqOk(reqOk)
  );

  dma_chan_ctl #(.EXT_ACK(EXT_PINS)) u_ctl (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .cntZero(cntZero), .cntLast(cntLast), .reqOk(reqOk), .busGnt(busGnt),
    .stb(stb), .busReq(busReq), .rdStb(rdStb), .wrStb(wrStb),
    .sizeWord(sizeWord), .ackOut(ackOut), .done(done)
  );

endmodule

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0, standby = 1'b0, cfgWe = 1'b0, cntWe = 1'b0;
  logic [6:0] cfgData = '0;
  logic [15:0] cntData = '0;
  logic reqN = 1'b1, busGnt = 1'b1;
  logic ackOut, busReq, rdStb, wrStb, sizeWord, done;
  logic auxAck, auxBusReq, auxRd, auxWr, auxSize, auxDone;

  always #2 clk = ~clk;

  dma_chan_ctrl #(.CHAN_ID(0)) u_dut (
    .clk(clk), .rstN(rstN), .standby(standby), .cfgWe(cfgWe), .cfgData(cfgData),
    .cntWe(cntWe), .cntData(cntData), .reqN(reqN), .ackOut(ackOut),
    .busReq(busReq), .busGnt(busGnt), .rdStb(rdStb), .wrStb(wrStb),
    .sizeWord(sizeWord), .done(done));

  dma_chan_ctrl #(.CHAN_ID(2)) u_aux (
    .clk(clk), .rstN(rstN), .standby(standby), .cfgWe(cfgWe), .cfgData(cfgData),
    .cntWe(cntWe), .cntData(cntData), .reqN(reqN), .ackOut(auxAck),
    .busReq(auxBusReq), .busGnt(busGnt), .rdStb(auxRd), .wrStb(auxWr),
    .sizeWord(auxSize), .done(auxDone));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // monitor state
  bit monOn = 1'b0;
  bit curPol, curPhase, curSingle, curWord;
  int rdCnt, wrCnt, ackCnt, ackMis, busRise, sizeMis, doneCnt, auxWrCnt, auxAckHi;
  logic prevBus = 1'b0;

  always @(posedge clk) begin
    #1;
    if (monOn) begin
      logic ackAct, ackWant;
      ackAct  = curPol ? ~ackOut : ackOut;
      ackWant = (curSingle || curPhase) ? wrStb : rdStb;
      if (rdStb) rdCnt++;
      if (wrStb) wrCnt++;
      if (ackAct) ackCnt++;
      if (ackAct != ackWant) ackMis++;
      if (busReq && !prevBus) busRise++;
      if ((rdStb || wrStb) && sizeWord != curWord) sizeMis++;
      if (done) doneCnt++;
      if (auxWr) auxWrCnt++;
      if (auxAck) auxAckHi++;
    end
    prevBus = busReq;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    rdCnt = 0; wrCnt = 0; ackCnt = 0; ackMis = 0; busRise = 0;
    sizeMis = 0; doneCnt = 0; auxWrCnt = 0; auxAckHi = 0;
  endtask

  task automatic doReset();
    monOn = 1'b0; reqN = 1'b1; busGnt = 1'b1;
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input int count, input logic [6:0] word);
    curWord = word[1]; curPol = word[4]; curPhase = word[5]; curSingle = word[6];
    cntWe = 1'b1; cntData = 16'(count);
    @(negedge clk); cntWe = 1'b0;
    cfgWe = 1'b1; cfgData = word;
    @(negedge clk); cfgWe = 1'b0;
    clearMon();
    monOn = 1'b1;
  endtask

  task automatic waitDone(input bit pulses);
    int guard = 0;
    while (doneCnt == 0 && guard < 600) begin
      if (pulses) begin
        reqN = 1'b0; repeat (2) @(negedge clk);
        reqN = 1'b1; repeat (6) @(negedge clk);
        guard += 8;
      end else begin
        @(negedge clk); guard++;
      end
    end
    reqN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state
    check(!busReq && !rdStb && !wrStb && !ackOut && !done, "R1 reset idle",
          {busReq, rdStb, wrStb, ackOut, done}, 0);

    // Sweep all option combinations over a 3-unit block
    for (int k = 0; k < 64; k++) begin
      bit single, phase, pol, edg, burst, word;
      logic [6:0] w;
      {single, phase, pol, edg, burst, word} = 6'(k);
      w = {single, phase, pol, edg, burst, word, 1'b1};
      doReset();
      setup(3, w);
      if (!edg) reqN = 1'b0;
      waitDone(edg);
      check(wrCnt == 3, "R9 write units", wrCnt, 3);
      check(rdCnt == (single ? 0 : 3), "R3 read units", rdCnt, single ? 0 : 3);
      check(ackCnt == 3 && ackMis == 0, "R2 ack phase", ackMis, 0);
      check(busRise == (burst ? 1 : 3), "R7 bus sessions", busRise, burst ? 1 : 3);
      check(sizeMis == 0, "R8 size", sizeMis, 0);
      check(doneCnt == 1, "R9 done pulse", doneCnt, 1);
      check(ackOut == pol, "R4 idle polarity", ackOut, pol);
      // enable cleared: request again, nothing must happen
      reqN = 1'b0; repeat (12) @(negedge clk); reqN = 1'b1;
      check(busRise == (burst ? 1 : 3), "R9 enable cleared", busRise, burst ? 1 : 3);
    end

    // R10: grant held off
    doReset();
    busGnt = 1'b0;
    setup(2, 7'b0000001);
    reqN = 1'b0;
    repeat (20) @(negedge clk);
    check(busReq && rdCnt == 0 && wrCnt == 0, "R10 no grant no strobe", rdCnt + wrCnt, 0);
    busGnt = 1'b1;
    waitDone(1'b0);
    check(wrCnt == 2, "R10 after grant", wrCnt, 2);

    // R6: no edge -> no transfer; held-low level -> one unit
    doReset();
    setup(3, 7'b0001001);
    repeat (30) @(negedge clk);
    check(wrCnt == 0, "R6 no edge", wrCnt, 0);
    reqN = 1'b0;
    repeat (40) @(negedge clk);
    check(wrCnt == 1, "R6 one unit per edge", wrCnt, 1);
    reqN = 1'b1;

    // R5: level mode, no request, then burst pause and resume
    doReset();
    setup(8, 7'b0000101);
    repeat (20) @(negedge clk);
    check(busRise == 0, "R5 high level no start", busRise, 0);
    reqN = 1'b0;
    begin
      int g = 0;
      while (wrCnt < 3 && g < 100) begin @(negedge clk); g++; end
    end
    reqN = 1'b1;
    repeat (10) @(negedge clk);
    begin
      int held;
      held = wrCnt;
      check(!busReq && wrCnt < 8, "R5 pause releases bus", busReq, 0);
      repeat (10) @(negedge clk);
      check(wrCnt == held, "R5 paused stays", wrCnt, held);
    end
    reqN = 1'b0;
    waitDone(1'b0);
    check(wrCnt == 8 && busRise >= 2, "R5 resume to end", wrCnt, 8);

    // R9: zero count
    doReset();
    setup(0, 7'b0000001);
    reqN = 1'b0;
    repeat (20) @(negedge clk);
    check(busRise == 0 && doneCnt == 0, "R9 zero count", busRise, 0);
    reqN = 1'b1;

    // R1: standby clears polarity and enable
    doReset();
    setup(2, 7'b0010001);
    repeat (2) @(negedge clk);
    check(ackOut == 1'b1, "R1 polarity set", ackOut, 1);
    standby = 1'b1; @(negedge clk); standby = 1'b0;
    @(negedge clk);
    check(ackOut == 1'b0, "R1 standby clears", ackOut, 0);
    reqN = 1'b0;
    repeat (20) @(negedge clk);
    check(busRise == 0, "R1 standby disables", busRise, 0);
    reqN = 1'b1;

    // R11: channel 2 ignores request pin and keeps ack low
    doReset();
    setup(3, 7'b0111001);
    repeat (40) @(negedge clk);
    check(auxWrCnt == 3, "R11 auto transfer", auxWrCnt, 3);
    check(auxAckHi == 0, "R11 ack held low", auxAckHi, 0);
    check(wrCnt == 0, "R6 channel 0 waits for edge", wrCnt, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule